// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-facing side of a small asynchronous serial port. It decodes a simple register bus (a 3-bit register select, read and write strobes, 16-bit write data) into a set of control registers. It holds an 8-entry transmit queue and an 8-entry receive queue, and it builds the line status word and the interrupt line from them. The serial engine that shifts bits on the wire is a separate block. It takes bytes from the transmit queue through a valid/take handshake and offers received bytes and overrun events on the receive side. It also reports whether its shifter is idle.

A global module-on bit in register 0 opens or closes every other register. While it is clear, the bus can only reach register 0. With the divisor-latch bit of the line control register set, the data register becomes a window onto the low byte of the 16-bit baud divisor and leaves both queues alone. Register select values: 0 module-on (bit 0), 1 data, 2 interrupt enable, 3 line control, 4 modem control, 5 line status (read-only), 6 extra control, 7 full 16-bit divisor.

Top module: `sport_regs`

## Requirements
- R1: While the module-on bit (register 0, bit 0) is 0, writes to registers 1 to 7 change nothing, and reads of them return 0 with no side effect. Register 0 is always readable and writable.
- R2: After reset, module-on, interrupt enable, line control, modem control and the divisor are 0, and extra control reads 0x0003. Once enabled, the line status reads 0x0060 (transmit idle).
- R3: With line control bit 7 set, a data-register write loads divisor bits 7:0 and a data-register read returns them. Neither touches the queues, and register 7 reads and writes all 16 divisor bits.
- R4: With line control bit 7 clear, a data-register write enqueues byte 7:0 into the transmit queue. A write to a full queue (8 entries) is dropped. The engine receives the bytes oldest first on tx_data while tx_valid is high, and each tx_take removes one.
- R5: With line control bit 7 clear, a data-register read returns the oldest received byte and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R6: Line status bit 0 is 1 exactly while the receive queue holds at least one byte.
- R7: Line status bit 1 (overrun) is set by an rx_overrun pulse or by a byte that arrives at a full receive queue, and that byte is discarded. A status read clears the bit. When a set and a clearing read fall in the same cycle, the read returns the old value and the bit ends up set.
- R8: Line status bit 5 is 1 while the transmit queue has room. Bit 6 is 1 while the transmit queue is empty and tx_idle is high. All other status bits read 0.
- R9: irq is high while module-on is 1 and either interrupt enable bit 1 is set with the transmit queue empty, or bit 0 is set with the receive queue holding a byte.
- R10: Received bytes and overrun events are taken only while module-on and extra control bit 0 are both 1. tx_valid is raised only while module-on and extra control bit 1 are both 1.
- R11: Unimplemented bits read as 0. Interrupt enable keeps bits 1:0, line control keeps bits 7, 6 and 0, modem control keeps bit 1, and extra control keeps bits 7:0. The stored fields drive cfg_eight_bit (line control bit 0), cfg_break (bit 6), cfg_rts (modem bit 1) and cfg_flow (extra control bits 7:2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_overrun | input | 1 | Engine reports a lost character |
| tx_idle | input | 1 | Engine shifter idle |
| tx_take | input | 1 | Engine takes the offered transmit byte |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Oldest transmit byte |
| cfg_divisor | output | 16 | Baud divisor |
| cfg_eight_bit | output | 1 | Eight-bit character mode |
| cfg_break | output | 1 | Hold the line low |
| cfg_rts | output | 1 | Modem request-to-send control |
| cfg_flow | output | 6 | Flow-control settings for the engine |
| irq | output | 1 | Interrupt request |

## Verification
The overrun flag can be set by the engine in the very cycle in which software reads the status register, which is the point where the clear-on-read would erase a fresh event. The bench raises rx_overrun during a status read. It expects that read to return the old value, and the next read to show bit 1 set before it clears. The receive queue can also be filled past eight entries, so the ninth byte must raise the same flag while reads continue to return the first eight in order.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        RG_ENABLE = 3'd0,
        RG_DATA   = 3'd1,
        RG_IEN    = 3'd2,
        RG_LCTL   = 3'd3,
        RG_MCTL   = 3'd4,
        RG_LSTAT  = 3'd5,
        RG_XCTL   = 3'd6,
        RG_DIV    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic latch;
        logic brk;
        logic eight;
    } lctl_t;

    typedef struct packed {
        logic [5:0] flow;
        logic       tx_en;
        logic       rx_en;
    } xctl_t;

    typedef struct packed {
        logic tx_done;
        logic tx_room;
        logic ovr;
        logic rx_ready;
    } lstat_t;

    localparam xctl_t XCTL_RESET = '{flow: 6'd0, tx_en: 1'b1, rx_en: 1'b1};

    function automatic logic [BUS_W-1:0] pack_lstat(lstat_t s);
        return {9'd0, s.tx_done, s.tx_room, 3'd0, s.ovr, s.rx_ready};
    endfunction

    function automatic logic [BUS_W-1:0] pack_lctl(lctl_t c);
        return {8'd0, c.latch, c.brk, 5'd0, c.eight};
    endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign count   = cnt;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4: a push into a full queue without a pop leaves it full and unchanged
    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

    // R4: an accepted push alone grows the occupancy by one
    a_r4_push_counts: assert property (@(posedge clk) disable iff (rst)
        (!full && push && !pop) |=> (count == $past(count) + 1'b1));

    // R5: a pop of an empty queue leaves it empty
    a_r5_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/sport_stat.sv
module sport_stat
    import sport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mod_en,
    input  logic [1:0] ien,
    input  logic       ovr_set,
    input  logic       ovr_clr,
    input  logic       rx_nonempty,
    input  logic       tx_full,
    input  logic       tx_empty,
    input  logic       tx_idle,
    output lstat_t     stat,
    output logic       irq
);

    logic ovr;

    always_ff @(posedge clk) begin
        if (rst)          ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end

    always_comb begin
        stat.rx_ready = rx_nonempty;
        stat.ovr      = ovr;
        stat.tx_room  = !tx_full;
        stat.tx_done  = tx_empty && tx_idle;
    end

    assign irq = mod_en && ((ien[1] && tx_empty) || (ien[0] && rx_nonempty));

    // R7: a set event always shows up in the flag one cycle later, even against a clearing read
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        ovr_set |=> stat.ovr);

    // R7: a clearing read with no new event leaves the flag low
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !ovr_set) |=> !stat.ovr);

    // R9: no interrupt while the module is off
    a_r9_irq_needs_on: assert property (@(posedge clk) disable iff (rst)
        irq |-> mod_en);

endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_overrun,
    input  logic              tx_idle,
    input  logic              tx_take,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic [BUS_W-1:0]  cfg_divisor,
    output logic              cfg_eight_bit,
    output logic              cfg_break,
    output logic              cfg_rts,
    output logic [5:0]        cfg_flow,
    output logic              irq
);

    reg_sel_e          sel;
    logic              mod_en;
    logic [1:0]        ien;
    lctl_t             lctl;
    logic              rts;
    xctl_t             xctl;
    logic [BUS_W-1:0]  div;
    lstat_t            stat;

    logic              open_sel, wr_go, rd_go;
    logic              rx_active, rx_push, rx_pop, tx_push, tx_pop;
    logic              rx_empty, rx_full, tx_empty, tx_full;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;

    assign sel      = reg_sel_e'(bus_addr);
    assign open_sel = mod_en || (sel == RG_ENABLE);
    assign wr_go    = bus_wr && open_sel;
    assign rd_go    = bus_rd && open_sel;

    assign rx_active = mod_en && xctl.rx_en;
    assign rx_push   = rx_valid && rx_active;
    assign rx_pop    = rd_go && (sel == RG_DATA) && !lctl.latch;
    assign tx_push   = wr_go && (sel == RG_DATA) && !lctl.latch;
    assign tx_valid  = mod_en && xctl.tx_en && !tx_empty;
    assign tx_pop    = tx_take && tx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_en <= 1'b0;
            ien    <= '0;
            lctl   <= '0;
            rts    <= 1'b0;
            xctl   <= XCTL_RESET;
            div    <= '0;
        end else if (wr_go) begin
            unique case (sel)
                RG_ENABLE: mod_en <= bus_wdata[0];
                RG_DATA:   if (lctl.latch) div[BYTE_W-1:0] <= bus_wdata[BYTE_W-1:0];
                RG_IEN:    ien <= bus_wdata[1:0];
                RG_LCTL:   lctl <= '{latch: bus_wdata[7], brk: bus_wdata[6], eight: bus_wdata[0]};
                RG_MCTL:   rts <= bus_wdata[1];
                RG_XCTL:   xctl <= xctl_t'(bus_wdata[7:0]);
                RG_DIV:    div <= bus_wdata;
                default:   ;
            endcase
        end
    end

    sport_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(bus_wdata[BYTE_W-1:0]),
        .pop(tx_pop), .dout(tx_data),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    sport_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    sport_stat u_stat (
        .clk(clk), .rst(rst),
        .mod_en(mod_en), .ien(ien),
        .ovr_set(rx_active && (rx_overrun || (rx_valid && rx_full))),
        .ovr_clr(rd_go && (sel == RG_LSTAT)),
        .rx_nonempty(!rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_idle(tx_idle), .stat(stat), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            unique case (sel)
                RG_ENABLE: bus_rdata = {{(BUS_W-1){1'b0}}, mod_en};
                RG_DATA:   bus_rdata = lctl.latch ? {8'd0, div[BYTE_W-1:0]}
                                     : (rx_empty ? '0 : {8'd0, rx_head});
                RG_IEN:    bus_rdata = {14'd0, ien};
                RG_LCTL:   bus_rdata = pack_lctl(lctl);
                RG_MCTL:   bus_rdata = {14'd0, rts, 1'b0};
                RG_LSTAT:  bus_rdata = pack_lstat(stat);
                RG_XCTL:   bus_rdata = {8'd0, xctl};
                RG_DIV:    bus_rdata = div;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign cfg_divisor   = div;
    assign cfg_eight_bit = lctl.eight;
    assign cfg_break     = lctl.brk;
    assign cfg_rts       = rts;
    assign cfg_flow      = xctl.flow;

    // R1: with the module off, bus writes to the gated registers leave them as they were
    a_r1_locked_regs: assert property (@(posedge clk) disable iff (rst)
        (!mod_en && bus_wr && (bus_addr != 3'd0))
        |=> ($stable(ien) && $stable(lctl) && $stable(div) && $stable(xctl) && $stable(rts)));

    // R3: a data read through the divisor window leaves the receive queue untouched
    a_r3_window_keeps_rxq: assert property (@(posedge clk) disable iff (rst)
        (rd_go && sel == RG_DATA && lctl.latch && !rx_push) |=> $stable(rx_cnt));

    // R10: a received byte with the receiver off never enters the queue
    a_r10_rx_gate: assert property (@(posedge clk) disable iff (rst)
        (!rx_active && !rx_pop) |=> $stable(rx_cnt));

endmodule

// File: tb/sim_sport_regs.sv
module sim_sport_regs;
    import sport_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_overrun = 1'b0, tx_idle = 1'b1, tx_take = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic [15:0] cfg_divisor;
    logic        cfg_eight_bit, cfg_break, cfg_rts, irq;
    logic [5:0]  cfg_flow;

    int tests = 0, fails = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    int tx_seen = 0;

    always #5 clk = ~clk;

    sport_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .tx_idle(tx_idle), .tx_take(tx_take), .tx_valid(tx_valid),
        .tx_data(tx_data), .cfg_divisor(cfg_divisor), .cfg_eight_bit(cfg_eight_bit),
        .cfg_break(cfg_break), .cfg_rts(cfg_rts), .cfg_flow(cfg_flow), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        #3 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // driver: queue a transmit byte and record what the engine must receive
    task automatic send(input logic [7:0] b, input bit accepted);
        wr(3'd1, {8'hA5, b});
        if (accepted) exp_tx.push_back(b);
    endtask

    task automatic rx_put(input logic [7:0] b, input bit accepted);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        if (accepted) exp_rx.push_back(b);
    endtask

    task automatic rx_get(input string req);
        logic [15:0] v;
        logic [7:0]  e;
        rd(3'd1, v);
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        chk(req, v, {8'h00, e});
    endtask

    // monitor: every byte the engine takes must be the oldest expected one
    always @(negedge clk) begin
        if (tx_take && tx_valid) begin
            tx_seen++;
            if (exp_tx.size() == 0) chk("R4 unexpected tx byte", {8'h00, tx_data}, 16'hFFFF);
            else chk("R4 tx order", {8'h00, tx_data}, {8'h00, exp_tx.pop_front()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state and gating while off
        rd_chk("R2 module-on reset", 3'd0, 16'h0000);
        rd_chk("R1 gated read while off", 3'd6, 16'h0000);
        wr(3'd3, 16'h0041);
        rx_put(8'h99, 1'b0);
        chk("R9 irq low while off", {15'd0, irq}, 16'h0000);
        wr(3'd0, 16'h0001);
        rd_chk("R2 module-on set", 3'd0, 16'h0001);
        rd_chk("R1 write while off dropped", 3'd3, 16'h0000);
        rd_chk("R10 byte while off dropped", 3'd5, 16'h0060);
        rd_chk("R2 extra control reset", 3'd6, 16'h0003);
        rd_chk("R2 interrupt enable reset", 3'd2, 16'h0000);
        rd_chk("R2 divisor reset", 3'd7, 16'h0000);

        // reserved bits and config outputs
        wr(3'd2, 16'hFFFF);
        rd_chk("R11 interrupt enable bits", 3'd2, 16'h0003);
        chk("R9 irq on empty tx", {15'd0, irq}, 16'h0001);
        wr(3'd4, 16'hFFFF);
        rd_chk("R11 modem control bits", 3'd4, 16'h0002);
        chk("R11 cfg_rts", {15'd0, cfg_rts}, 16'h0001);
        wr(3'd3, 16'hFF7F);
        rd_chk("R11 line control bits", 3'd3, 16'h0041);
        chk("R11 cfg break/eight", {14'd0, cfg_break, cfg_eight_bit}, 16'h0003);
        wr(3'd6, 16'hFFFF);
        chk("R11 cfg_flow", {10'd0, cfg_flow}, 16'h003F);
        rd_chk("R11 extra control bits", 3'd6, 16'h00FF);
        wr(3'd6, 16'h0003);
        wr(3'd2, 16'h0001);
        chk("R9 rx-only irq with empty rx", {15'd0, irq}, 16'h0000);

        // divisor window
        wr(3'd3, 16'h0081);
        wr(3'd1, 16'h005A);
        rd_chk("R3 window write lands in divisor", 3'd7, 16'h005A);
        rd_chk("R3 tx queue untouched", 3'd5, 16'h0060);
        wr(3'd7, 16'h1234);
        chk("R3 cfg_divisor", cfg_divisor, 16'h1234);
        rd_chk("R3 window read", 3'd1, 16'h0034);
        wr(3'd3, 16'h0001);

        // transmit queue fill, overflow and drain
        for (int i = 0; i < 9; i++) send(8'h10 + 8'(i), i < 8);
        rd_chk("R8 full tx queue status", 3'd5, 16'h0000);
        chk("R4 tx_valid with data", {15'd0, tx_valid}, 16'h0001);
        @(posedge clk); #1 tx_take = 1'b1;
        repeat (12) @(posedge clk);
        #1 tx_take = 1'b0;
        chk("R4 eight bytes delivered", 16'(tx_seen), 16'd8);
        chk("R4 scoreboard drained", 16'(exp_tx.size()), 16'd0);
        rd_chk("R8 empty and idle", 3'd5, 16'h0060);
        tx_idle = 1'b0;
        rd_chk("R8 shifter busy", 3'd5, 16'h0020);
        tx_idle = 1'b1;

        // receive path
        for (int i = 0; i < 3; i++) rx_put(8'hC0 + 8'(i), 1'b1);
        rd_chk("R6 rx ready", 3'd5, 16'h0061);
        chk("R9 rx irq", {15'd0, irq}, 16'h0001);
        for (int i = 0; i < 3; i++) rx_get("R5 rx order");
        rx_get("R5 empty read returns zero");
        rd_chk("R6 rx drained", 3'd5, 16'h0060);

        // overrun by a full queue
        for (int i = 0; i < 9; i++) rx_put(8'h40 + 8'(i), i < 8);
        rd_chk("R7 overrun on full queue", 3'd5, 16'h0063);
        rd_chk("R7 cleared by read", 3'd5, 16'h0061);
        for (int i = 0; i < 8; i++) rx_get("R7 surviving bytes in order");
        rx_get("R7 ninth byte discarded");

        // overrun pulse and the same-cycle set/clear
        @(posedge clk); #1 rx_overrun = 1'b1;
        @(posedge clk); #1 rx_overrun = 1'b0;
        rd_chk("R7 pulse sets overrun", 3'd5, 16'h0062);
        @(posedge clk); #1;
        bus_addr = 3'd5; bus_rd = 1'b1; rx_overrun = 1'b1;
        #3 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; rx_overrun = 1'b0;
        chk("R7 read during set sees old value", v, 16'h0060);
        rd_chk("R7 set wins over clear", 3'd5, 16'h0062);
        rd_chk("R7 then clears", 3'd5, 16'h0060);

        // receiver and transmitter enables
        wr(3'd6, 16'h0002);
        rx_put(8'h77, 1'b0);
        rd_chk("R10 receiver off drops byte", 3'd5, 16'h0060);
        wr(3'd6, 16'h0001);
        send(8'h5C, 1'b1);
        @(posedge clk); #1 tx_take = 1'b1;
        repeat (3) @(posedge clk);
        chk("R10 transmitter off holds tx_valid low", {15'd0, tx_valid}, 16'h0000);
        wr(3'd6, 16'h0003);
        repeat (3) @(posedge clk);
        #1 tx_take = 1'b0;
        chk("R4 held byte delivered", 16'(exp_tx.size()), 16'd0);

        // switching off closes the bus and the interrupt
        wr(3'd2, 16'h0002);
        chk("R9 tx irq", {15'd0, irq}, 16'h0001);
        wr(3'd0, 16'h0000);
        chk("R9 irq off with module", {15'd0, irq}, 16'h0000);
        rd_chk("R1 status hidden while off", 3'd5, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule